// File: doc/BRIEF.md
# Display Memory Blanking Sequencer

This block holds the character codes and per-character flash flags of a small dot-matrix display, together with the control word, the user-glyph address register and a free-running blink/flash timer. It blanks the two display memories in one of two ways. Software sets the clear bit of the control word, and the memories are wiped while every other piece of state is kept. The external active-low reset pin also zeroes the control word and the timer, then runs the same wipe once the pin is released.

Both wipes are a fixed three-cycle sweep. In sweep cycle k, every entry whose index modulo three equals k is loaded with the space code and has its flash flag cleared. While a sweep is running, or while the pin is held low, the busy output is high and every host write is discarded. Reads are combinational and are always allowed, so the progress of a sweep can be observed.

Top module: `dmb_blanker`

## Requirements
- R1: A control-word write (select 2) whose bit 7 is 1, accepted while idle, starts a clear. busy is high from the next cycle for exactly three cycles. A control-word write with bit 7 equal to 0 only stores the word and starts no clear.
- R2: When a clear finishes, every character entry reads 0x20 and every flash entry reads 0.
- R3: A clear leaves control-word bits 6:0, the user-glyph address register and the timer unchanged.
- R4: Bit 7 of the control word reads 1 while the clear runs and reads 0 from the cycle in which busy falls.
- R5: On each clock edge where rst_n is low, the control word and the timer become 0 and busy becomes 1.
- R6: After rst_n rises, busy stays high for exactly three further cycles. After that, all character entries read 0x20 and all flash entries read 0, and the user-glyph address register keeps its value.
- R7: Host writes to any target are dropped while busy is high or rst_n is low.
- R8: A low level on rst_n during a clear aborts the clear. A full three-cycle reset sweep then follows the release of rst_n.
- R9: The timer advances by one, modulo 2^TMR_W, on every edge where rst_n is high. This includes edges during a clear.
- R10: wr_sel and rd_sel share one encoding: 0 selects a character code, 1 selects a flash flag (bit 0), 2 selects the control word and 3 selects the user-glyph address (low 4 bits). A read returns the current state in the same cycle.
- R11: On the k-th edge of a sweep (k = 0, 1, 2), exactly the entries with index mod 3 == k are blanked. The other entries keep their values until their own edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External reset, active low, sampled on the clock |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Write target (see R10) |
| wr_addr | input | 3 | Character index for targets 0 and 1 |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Read target (see R10) |
| rd_addr | input | 3 | Character index for targets 0 and 1 |
| rd_data | output | 8 | Read data, combinational |
| busy | output | 1 | High while reset is held or a sweep runs |
| tmr_value | output | 6 | Flash/blink timer value |

## Verification
busy rises one edge after the accepting write and falls on the third sweep edge after that. Bit 7 drops on that same edge, and each entry changes on the sweep edge that matches its index modulo three. The timer moves on every edge, and read data follows the select inputs within the same cycle. The bench drives every input just after the falling edge. It compares busy, the timer and the selected read value one time unit later against a behavioural model advanced once per rising edge, so each result is examined in the first cycle it is due. It also examines entries that have not yet been swept, as well as those already blanked.

// File: rtl/dmb_pkg.sv
package dmb_pkg;

    typedef enum logic [1:0] {
        SEL_CHAR  = 2'd0,
        SEL_FLASH = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_UDC   = 2'd3
    } dmb_sel_e;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_CLEAR = 2'd1,
        MODE_RESET = 2'd2
    } dmb_mode_e;

endpackage

// File: rtl/dmb_seq.sv
module dmb_seq
    import dmb_pkg::*;
#(
    parameter int SWEEP_LEN = 3,
    parameter int PH_W      = (SWEEP_LEN > 1) ? $clog2(SWEEP_LEN) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_req,
    output logic            busy,
    output logic            sweep_en,
    output logic [PH_W-1:0] sweep_phase,
    output logic            clear_done
);

    localparam logic [PH_W-1:0] LAST  = PH_W'(SWEEP_LEN - 1);
    localparam int              RUN_W = $clog2(SWEEP_LEN + 2) + 1;

    typedef struct packed {
        dmb_mode_e        mode;
        logic [PH_W-1:0]  phase;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.mode  = MODE_RESET;
            st_d.phase = '0;
        end else if (st_q.mode != MODE_IDLE) begin
            if (st_q.phase == LAST) begin
                st_d.mode  = MODE_IDLE;
                st_d.phase = '0;
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end else if (clear_req) begin
            st_d.mode  = MODE_CLEAR;
            st_d.phase = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign busy        = (st_q.mode != MODE_IDLE);
    assign sweep_en    = rst_n && (st_q.mode != MODE_IDLE);
    assign sweep_phase = st_q.phase;
    assign clear_done  = rst_n && (st_q.mode == MODE_CLEAR) && (st_q.phase == LAST);

    // run-length counter used only by the span check below
    logic [RUN_W-1:0] run_q;
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) run_q <= '0;
        else                 run_q <= run_q + 1'b1;
    end

    // R1 / R6: every busy window seen with the pin high lasts SWEEP_LEN cycles
    p_busy_span_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == RUN_W'(SWEEP_LEN)))
        else $error("busy window length wrong");

    // R8: a pin reset always forces the reset mode, even mid-clear
    p_reset_wins_r8: assert property (@(posedge clk)
        !rst_n |=> (st_q.mode == MODE_RESET && st_q.phase == '0))
        else $error("reset did not take priority");

endmodule

// File: rtl/dmb_bank.sv
module dmb_bank #(
    parameter int          NUM_CHARS = 8,
    parameter int          DATA_W    = 8,
    parameter int          SWEEP_LEN = 3,
    parameter logic [7:0]  BLANK     = 8'h20,
    parameter int          AW        = (NUM_CHARS > 1) ? $clog2(NUM_CHARS) : 1,
    parameter int          PH_W      = (SWEEP_LEN > 1) ? $clog2(SWEEP_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_char,
    input  logic              wr_flash,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sweep_en,
    input  logic [PH_W-1:0]   sweep_phase,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_char,
    output logic              rd_flash
);

    localparam logic [DATA_W-1:0] BLANK_W = DATA_W'(BLANK);
    localparam logic [PH_W-1:0]   LAST    = PH_W'(SWEEP_LEN - 1);

    typedef struct packed {
        logic [DATA_W-1:0] code;
        logic              flash;
    } ent_t;

    logic [DATA_W-1:0] code_q  [NUM_CHARS];
    logic              flash_q [NUM_CHARS];

    for (genvar i = 0; i < NUM_CHARS; i++) begin : g_ent
        localparam logic [PH_W-1:0] SLICE = PH_W'(i % SWEEP_LEN);
        ent_t e_d, e_q;

        always_comb begin
            e_d = e_q;
            if (sweep_en && sweep_phase == SLICE) begin
                e_d.code  = BLANK_W;
                e_d.flash = 1'b0;
            end else begin
                if (wr_char && wr_addr == AW'(i))  e_d.code  = wr_data;
                if (wr_flash && wr_addr == AW'(i)) e_d.flash = wr_data[0];
            end
        end

        always_ff @(posedge clk) begin
            e_q <= e_d;
        end

        assign code_q[i]  = e_q.code;
        assign flash_q[i] = e_q.flash;

        // R11: an entry is blank right after its own sweep slice
        p_slice_wipe_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (sweep_en && sweep_phase == SLICE) |=> (e_q.code == BLANK_W && !e_q.flash))
            else $error("entry not blanked on its slice");
    end

    always_comb begin
        rd_char  = '0;
        rd_flash = 1'b0;
        for (int k = 0; k < NUM_CHARS; k++) begin
            if (rd_addr == AW'(k)) begin
                rd_char  = code_q[k];
                rd_flash = flash_q[k];
            end
        end
    end

    logic all_blank;
    always_comb begin
        all_blank = 1'b1;
        for (int k = 0; k < NUM_CHARS; k++) begin
            if (code_q[k] != BLANK_W || flash_q[k]) all_blank = 1'b0;
        end
    end

    // R2 / R6: the whole bank is blank once the last slice has been swept
    p_bank_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_en && sweep_phase == LAST) |=> all_blank)
        else $error("bank not blank after sweep");

endmodule

// File: rtl/dmb_ctrl.sv
module dmb_ctrl #(
    parameter int DATA_W    = 8,
    parameter int CLEAR_BIT = 7,
    parameter int UADDR_W   = 4,
    parameter int TMR_W     = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               busy,
    input  logic               wr_ctrl,
    input  logic               wr_udc,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               clear_done,
    output logic [DATA_W-1:0]  ctrl_word,
    output logic [UADDR_W-1:0] udc_addr,
    output logic [TMR_W-1:0]   tmr_value
);

    typedef struct packed {
        logic [DATA_W-1:0]  ctrl;
        logic [UADDR_W-1:0] udc;
        logic [TMR_W-1:0]   tmr;
    } reg_t;

    reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!rst_n) begin
            r_d.ctrl = '0;
            r_d.tmr  = '0;
        end else begin
            r_d.tmr = r_q.tmr + 1'b1;
            if (wr_ctrl)    r_d.ctrl = wr_data;
            if (clear_done) r_d.ctrl[CLEAR_BIT] = 1'b0;
            if (wr_udc)     r_d.udc = wr_data[UADDR_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign ctrl_word = r_q.ctrl;
    assign udc_addr  = r_q.udc;
    assign tmr_value = r_q.tmr;

    // R7 / R3: the glyph address cannot move while a sweep runs
    p_udc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(r_q.udc))
        else $error("glyph address changed while busy");

    // R5: a low pin leaves a zero control word and timer
    p_pin_zero_r5: assert property (@(posedge clk)
        !rst_n |=> (r_q.ctrl == '0 && r_q.tmr == '0))
        else $error("control word or timer not zeroed");

endmodule

// File: rtl/dmb_blanker.sv
module dmb_blanker
    import dmb_pkg::*;
#(
    parameter int          NUM_CHARS = 8,
    parameter int          DATA_W    = 8,
    parameter int          CLEAR_BIT = 7,
    parameter int          UADDR_W   = 4,
    parameter int          TMR_W     = 6,
    parameter int          SWEEP_LEN = 3,
    parameter logic [7:0]  BLANK     = 8'h20,
    parameter int          AW        = (NUM_CHARS > 1) ? $clog2(NUM_CHARS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic [TMR_W-1:0]  tmr_value
);

    localparam int PH_W = (SWEEP_LEN > 1) ? $clog2(SWEEP_LEN) : 1;

    logic               wr_ok;
    logic               clear_req;
    logic               sweep_en;
    logic [PH_W-1:0]    sweep_phase;
    logic               clear_done;
    logic [DATA_W-1:0]  ctrl_word;
    logic [UADDR_W-1:0] udc_addr;
    logic [DATA_W-1:0]  rd_char;
    logic               rd_flash;
    dmb_sel_e           wsel, rsel;

    assign wsel      = dmb_sel_e'(wr_sel);
    assign rsel      = dmb_sel_e'(rd_sel);
    assign wr_ok     = wr_en && rst_n && !busy;
    assign clear_req = wr_ok && (wsel == SEL_CTRL) && wr_data[CLEAR_BIT];

    dmb_seq #(
        .SWEEP_LEN (SWEEP_LEN),
        .PH_W      (PH_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_req   (clear_req),
        .busy        (busy),
        .sweep_en    (sweep_en),
        .sweep_phase (sweep_phase),
        .clear_done  (clear_done)
    );

    dmb_bank #(
        .NUM_CHARS (NUM_CHARS),
        .DATA_W    (DATA_W),
        .SWEEP_LEN (SWEEP_LEN),
        .BLANK     (BLANK),
        .AW        (AW),
        .PH_W      (PH_W)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_char     (wr_ok && wsel == SEL_CHAR),
        .wr_flash    (wr_ok && wsel == SEL_FLASH),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .sweep_en    (sweep_en),
        .sweep_phase (sweep_phase),
        .rd_addr     (rd_addr),
        .rd_char     (rd_char),
        .rd_flash    (rd_flash)
    );

    dmb_ctrl #(
        .DATA_W    (DATA_W),
        .CLEAR_BIT (CLEAR_BIT),
        .UADDR_W   (UADDR_W),
        .TMR_W     (TMR_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .wr_ctrl    (wr_ok && wsel == SEL_CTRL),
        .wr_udc     (wr_ok && wsel == SEL_UDC),
        .wr_data    (wr_data),
        .clear_done (clear_done),
        .ctrl_word  (ctrl_word),
        .udc_addr   (udc_addr),
        .tmr_value  (tmr_value)
    );

    always_comb begin
        case (rsel)
            SEL_CHAR:  rd_data = rd_char;
            SEL_FLASH: rd_data = {{(DATA_W-1){1'b0}}, rd_flash};
            SEL_CTRL:  rd_data = ctrl_word;
            default:   rd_data = DATA_W'(udc_addr);
        endcase
    end

    // R4: the clear bit is down whenever a busy window ends
    p_bit_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !ctrl_word[CLEAR_BIT])
        else $error("clear bit still set after sweep");

    // R5: holding the pin low always shows busy
    p_busy_pin_r5: assert property (@(posedge clk)
        !rst_n |=> busy)
        else $error("busy low during pin reset");

endmodule

// File: tb/tb_dmb_blanker.sv
module tb_dmb_blanker;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [1:0] wr_sel;
    logic [2:0] wr_addr;
    logic [7:0] wr_data;
    logic [1:0] rd_sel;
    logic [2:0] rd_addr;
    logic [7:0] rd_data;
    logic       busy;
    logic [5:0] tmr_value;

    always #4 clk = ~clk;

    dmb_blanker dut (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_sel (wr_sel),
        .wr_addr (wr_addr), .wr_data (wr_data), .rd_sel (rd_sel),
        .rd_addr (rd_addr), .rd_data (rd_data), .busy (busy),
        .tmr_value (tmr_value)
    );

    int vecs = 0;
    int bad  = 0;
    bit finished = 0;

    // behavioural model
    int m_char [8];
    bit m_cv   [8];
    int m_fl   [8];
    bit m_fv   [8];
    int m_ctrl = 0;
    int m_udc  = 0;
    bit m_uv   = 0;
    int m_tmr  = 0;
    int m_mode = 2;   // 0 idle, 1 clear, 2 reset
    int m_ph   = 0;

    task automatic chk(input string tag, input string what, input logic [31:0] got, input int exp);
        vecs++;
        if (got !== 32'(exp)) begin
            bad++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic cyc(input bit rst, input bit we, input int sel, input int addr,
                       input int data, input int rs, input int ra, input string tag);
        rst_n   = rst;
        wr_en   = we;
        wr_sel  = 2'(sel);
        wr_addr = 3'(addr);
        wr_data = 8'(data);
        rd_sel  = 2'(rs);
        rd_addr = 3'(ra);
        #1;
        chk(tag, "busy", 32'(busy), (m_mode != 0) ? 1 : 0);
        chk(tag, "timer", 32'(tmr_value), m_tmr);
        case (rs)
            0: if (m_cv[ra]) chk(tag, "char", 32'(rd_data), m_char[ra]);
            1: if (m_fv[ra]) chk(tag, "flash", 32'(rd_data), m_fl[ra]);
            2: chk(tag, "ctrl", 32'(rd_data), m_ctrl);
            default: if (m_uv) chk(tag, "glyph addr", 32'(rd_data), m_udc);
        endcase
        // model advance for the coming rising edge
        if (!rst) begin
            m_mode = 2; m_ph = 0; m_ctrl = 0; m_tmr = 0;
        end else begin
            m_tmr = (m_tmr + 1) % 64;
            if (m_mode != 0) begin
                for (int k = 0; k < 8; k++) begin
                    if (k % 3 == m_ph) begin
                        m_char[k] = 32; m_cv[k] = 1; m_fl[k] = 0; m_fv[k] = 1;
                    end
                end
                if (m_ph == 2) begin
                    if (m_mode == 1) m_ctrl = m_ctrl & 127;
                    m_mode = 0; m_ph = 0;
                end else begin
                    m_ph++;
                end
            end else if (we) begin
                case (sel)
                    0: begin m_char[addr] = data & 255; m_cv[addr] = 1; end
                    1: begin m_fl[addr] = data & 1; m_fv[addr] = 1; end
                    2: begin
                        m_ctrl = data & 255;
                        if ((data & 128) != 0) begin m_mode = 1; m_ph = 0; end
                    end
                    default: begin m_udc = data & 15; m_uv = 1; end
                endcase
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic fill(input int base, input string tag);
        for (int i = 0; i < 8; i++) cyc(1, 1, 0, i, base + i, 0, i, tag);
        for (int i = 0; i < 8; i++) cyc(1, 1, 1, i, i & 1, 1, i, tag);
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < 8; i++) cyc(1, 0, 0, 0, 0, 0, i, tag);
        for (int i = 0; i < 8; i++) cyc(1, 0, 0, 0, 0, 1, i, tag);
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog: got running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_addr = '0; wr_data = '0;
        rd_sel = 2'd2; rd_addr = '0;
        for (int k = 0; k < 8; k++) begin m_cv[k] = 0; m_fv[k] = 0; end
        @(negedge clk);

        // R5: pin held low, writes dropped (R7)
        cyc(0, 0, 0, 0, 0, 2, 0, "R5");
        cyc(0, 1, 2, 0, 8'h3C, 2, 0, "R7");
        cyc(0, 1, 3, 0, 5, 3, 0, "R5");

        // R6 / R11: sweep after release, observing the slices
        cyc(1, 0, 0, 0, 0, 0, 0, "R11");
        cyc(1, 0, 0, 0, 0, 0, 3, "R11");
        cyc(1, 0, 0, 0, 0, 0, 1, "R11");
        read_all("R6");

        // R10: writes and reads on every target
        cyc(1, 1, 3, 0, 8'hFA, 3, 0, "R10");
        fill(8'h41, "R10");
        cyc(1, 1, 2, 0, 8'h15, 2, 0, "R1");
        cyc(1, 0, 0, 0, 0, 2, 0, "R1");
        read_all("R10");

        // R1..R4, R7, R11: software clear
        cyc(1, 1, 2, 0, 8'h95, 2, 0, "R1");
        cyc(1, 1, 0, 1, 8'h7E, 0, 0, "R11");
        cyc(1, 1, 3, 0, 5, 0, 1, "R7");
        cyc(1, 1, 1, 2, 1, 2, 0, "R4");
        cyc(1, 0, 0, 0, 0, 2, 0, "R4");
        cyc(1, 0, 0, 0, 0, 3, 0, "R3");
        read_all("R2");

        // R8: pin reset in the middle of a clear
        fill(8'h61, "R8");
        cyc(1, 1, 3, 0, 8'h3, 3, 0, "R8");
        cyc(1, 1, 2, 0, 8'hC2, 2, 0, "R8");
        cyc(1, 0, 0, 0, 0, 0, 0, "R8");
        cyc(0, 0, 0, 0, 0, 0, 4, "R8");
        cyc(0, 0, 0, 0, 0, 2, 0, "R8");
        cyc(1, 0, 0, 0, 0, 0, 7, "R8");
        cyc(1, 1, 0, 5, 8'h11, 0, 5, "R7");
        cyc(1, 0, 0, 0, 0, 0, 2, "R8");
        cyc(1, 0, 0, 0, 0, 3, 0, "R6");
        read_all("R8");

        // R9: timer wraps while idle
        for (int i = 0; i < 70; i++) cyc(1, 0, 0, 0, 0, 3, 0, "R9");

        finished = 1;
        summary();
        $finish;
    end

endmodule